// File: doc/BRIEF.md
# Bit-Serial Single-Stage Instruction Sequencer

This block is the control sequencer of a bit-serial processor core for instructions that complete in one execution stage. It fetches an instruction word over a request/acknowledge bus. It keeps the opcode, the minor function code and the immediate field of that word. It then strobes a request to the register file and, once the register file reports ready, runs an execution stage of exactly 32 clock cycles. Each cycle of the stage handles one operand bit, starting at the least significant bit.

During the stage, the block raises a bit-counter enable and a program-counter enable together. It keeps the initialisation and trap indications low. It streams out the next program counter one bit per cycle, computed as the current program counter plus four by a serial adder with a single carry flip-flop. The shifted-in sum becomes the address of the next fetch.

Flow control at the fetch edge works as follows. Once raised, the request line stays up until the memory answers, so the memory applies back-pressure by withholding the acknowledge. An acknowledge that arrives while no request is open is discarded. The register-file side holds off the stage by keeping its ready input low.

Top module: `serial_stage_seq`

## Requirements
- R1: While reset is asserted and directly after it, the block is in fetch: `fetch_cyc`=1, `cnt_en`=0, `pc_en`=0, `rf_rreq`=0, `bit_idx`=0, and `fetch_adr` equals the parameter `PC_RESET`.
- R2: `fetch_cyc` stays high in every cycle until `fetch_ack` is seen high together with it, and it is low in the cycle after that acknowledge.
- R3: On the acknowledge cycle the block captures `fetch_rdata[6:0]` into `opcode`, `fetch_rdata[14:12]` into `funct3` and `fetch_rdata[31:20]` into `imm`. These outputs hold their values until the next accepted acknowledge.
- R4: `rf_rreq` is high for exactly one cycle, namely the cycle after the accepted acknowledge.
- R5: The stage begins (`cnt_en` rises) in the cycle after `rf_ready` is sampled high while the block waits for the register file, and never before that.
- R6: A stage lasts exactly 32 consecutive cycles, and `bit_idx` counts 0, 1, …, 31 across them.
- R7: `pc_en` equals `cnt_en` in every cycle, so both rise and fall together.
- R8: `init` and `trap` are low in every cycle.
- R9: In the stage cycle with `bit_idx`=k, `pc_sum` equals bit k of (PC + 4) mod 2^32. After the stage, `fetch_adr` holds that sum.
- R10: `fetch_cyc` is low for the whole stage and goes high again in the cycle right after the cycle with `bit_idx`=31.
- R11: A `fetch_ack` that arrives while `fetch_cyc` is low changes neither `opcode`, `funct3` nor `imm`, and it raises no `rf_rreq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_cyc | output | 1 | Instruction fetch request, held until acknowledged |
| fetch_adr | output | XLEN | Fetch address (current program counter) |
| fetch_ack | input | 1 | Memory acknowledge; data valid in the same cycle |
| fetch_rdata | input | XLEN | Returned instruction word |
| rf_rreq | output | 1 | One-cycle register-file access request |
| rf_ready | input | 1 | Register file ready to start the stage |
| cnt_en | output | 1 | Bit-counter enable, high during the stage |
| pc_en | output | 1 | Program-counter update enable |
| init | output | 1 | Initialisation-stage indication (always low here) |
| trap | output | 1 | Trap indication (always low here) |
| bit_idx | output | 5 | Index of the bit handled in the current stage cycle |
| pc_sum | output | 1 | Serial bit of the next program counter |
| opcode | output | 7 | Captured opcode field |
| funct3 | output | 3 | Captured minor function field |
| imm | output | 12 | Captured immediate field |

## Verification
Two events can coincide. First, a stray acknowledge can arrive in the same cycle that the register-file request strobe is out, or while the block is waiting for ready. Second, the ready input can be high in the very cycle that the request strobe is raised. The bench drives both cases. It asserts a foreign acknowledge carrying different data during the wait and checks that the captured fields and the strobe do not move. It also applies ready with no delay and checks that the stage still begins exactly one cycle later, with the serial sum, including the wrap of the address past the top of the range, matching the scoreboard bit by bit.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  localparam int OPC_W = 7;
  localparam int F3_W  = 3;
  localparam int IMM_W = 12;
  localparam int OPC_LSB = 0;
  localparam int F3_LSB  = 12;
  localparam int IMM_LSB = 20;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_RFWAIT = 2'd1,
    ST_EXEC   = 2'd2
  } ssq_state_e;

  typedef struct packed {
    logic [IMM_W-1:0] imm;
    logic [F3_W-1:0]  funct3;
    logic [OPC_W-1:0] opcode;
  } ssq_fields_t;
endpackage

// File: rtl/ssq_bitcnt.sv
module ssq_bitcnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (run)    cnt <= cnt + 1'b1;
    else             cnt <= '0;
  end

  assign last = run && (cnt == CNT_MAX);
endmodule

// File: rtl/ssq_fields.sv
module ssq_fields #(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic [XLEN-1:0]     word,
  output ssq_pkg::ssq_fields_t fields
);
  import ssq_pkg::*;

  ssq_fields_t nxt;

  always_comb begin
    nxt.opcode = word[OPC_LSB +: OPC_W];
    nxt.funct3 = word[F3_LSB  +: F3_W];
    nxt.imm    = word[IMM_LSB +: IMM_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       fields <= '0;
    else if (capture) fields <= nxt;
  end
endmodule

// File: rtl/ssq_pcadd.sv
module ssq_pcadd #(
  parameter int              XLEN     = 32,
  parameter int              CNT_W    = 5,
  parameter logic [XLEN-1:0] PC_RESET = '0,
  parameter logic [XLEN-1:0] PC_STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] bit_idx,
  output logic [XLEN-1:0]  pc_q,
  output logic             sum_bit
);
  logic carry_q;
  logic addend;
  logic carry_nxt;

  assign addend    = PC_STEP[bit_idx];
  assign sum_bit   = run & (pc_q[0] ^ addend ^ carry_q);
  assign carry_nxt = (pc_q[0] & addend) | (pc_q[0] & carry_q) | (addend & carry_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= PC_RESET;
      carry_q <= 1'b0;
    end else if (run) begin
      pc_q    <= {sum_bit, pc_q[XLEN-1:1]};
      carry_q <= carry_nxt;
    end else begin
      carry_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ssq_ctrl.sv
module ssq_ctrl (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_ack,
  input  logic                rf_ready,
  input  logic                last_bit,
  output ssq_pkg::ssq_state_e state,
  output logic                capture,
  output logic                rreq
);
  import ssq_pkg::*;

  ssq_state_e nxt;

  assign capture = (state == ST_FETCH) && fetch_ack;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FETCH:  if (fetch_ack) nxt = ST_RFWAIT;
      ST_RFWAIT: if (rf_ready)  nxt = ST_EXEC;
      ST_EXEC:   if (last_bit)  nxt = ST_FETCH;
      default:                  nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_FETCH;
      rreq  <= 1'b0;
    end else begin
      state <= nxt;
      rreq  <= capture;
    end
  end
endmodule

// File: rtl/serial_stage_seq.sv
module serial_stage_seq #(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] PC_RESET = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic                     fetch_cyc,
  output logic [XLEN-1:0]          fetch_adr,
  input  logic                     fetch_ack,
  input  logic [XLEN-1:0]          fetch_rdata,
  output logic                     rf_rreq,
  input  logic                     rf_ready,
  output logic                     cnt_en,
  output logic                     pc_en,
  output logic                     init,
  output logic                     trap,
  output logic [$clog2(XLEN)-1:0]  bit_idx,
  output logic                     pc_sum,
  output logic [ssq_pkg::OPC_W-1:0] opcode,
  output logic [ssq_pkg::F3_W-1:0]  funct3,
  output logic [ssq_pkg::IMM_W-1:0] imm
);
  import ssq_pkg::*;

  localparam int CNT_W = $clog2(XLEN);

  ssq_state_e  state;
  logic        capture;
  logic        running;
  logic        last_bit;
  ssq_fields_t fields;

  ssq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_ack (fetch_ack),
    .rf_ready  (rf_ready),
    .last_bit  (last_bit),
    .state     (state),
    .capture   (capture),
    .rreq      (rf_rreq)
  );

  assign running = (state == ST_EXEC);

  ssq_bitcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .cnt   (bit_idx),
    .last  (last_bit)
  );

  ssq_fields #(.XLEN(XLEN)) u_fields (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .word    (fetch_rdata),
    .fields  (fields)
  );

  ssq_pcadd #(
    .XLEN     (XLEN),
    .CNT_W    (CNT_W),
    .PC_RESET (PC_RESET),
    .PC_STEP  (XLEN'(4))
  ) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .bit_idx (bit_idx),
    .pc_q    (fetch_adr),
    .sum_bit (pc_sum)
  );

  assign fetch_cyc = (state == ST_FETCH);
  assign cnt_en    = running;
  assign pc_en     = running;
  assign init      = 1'b0;
  assign trap      = 1'b0;
  assign opcode    = fields.opcode;
  assign funct3    = fields.funct3;
  assign imm       = fields.imm;
endmodule

// File: rtl/ssq_checker.sv
module ssq_checker #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_cyc,
  input logic             fetch_ack,
  input logic             rf_rreq,
  input logic             rf_ready,
  input logic             cnt_en,
  input logic             pc_en,
  input logic             init,
  input logic             trap,
  input logic [CNT_W-1:0] bit_idx,
  input logic [6:0]       opcode,
  input logic [2:0]       funct3,
  input logic [11:0]      imm
);
  // R2
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_cyc && !fetch_ack) |=> fetch_cyc);

  // R2
  cyc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_cyc && fetch_ack) |=> !fetch_cyc);

  // R4
  rreq_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_cyc && fetch_ack) |=> rf_rreq);

  // R4
  rreq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rreq |=> !rf_rreq);

  // R3
  fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_cyc |=> (fetch_cyc || ($stable(opcode) && $stable(funct3) && $stable(imm))));

  // R5
  start_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_en) |-> $past(rf_ready));

  // R6
  stage_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_en) |-> (bit_idx == '0));

  // R6
  stage_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnt_en) |-> ($past(bit_idx) == {CNT_W{1'b1}}));

  // R7
  enables_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_en == cnt_en);

  // R8
  no_init_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init && !trap);

  // R10
  no_fetch_in_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_cyc && cnt_en));

  // R10
  refetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnt_en) |-> fetch_cyc);
endmodule

bind serial_stage_seq ssq_checker #(.CNT_W($clog2(XLEN))) u_ssq_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .fetch_cyc (fetch_cyc),
  .fetch_ack (fetch_ack),
  .rf_rreq   (rf_rreq),
  .rf_ready  (rf_ready),
  .cnt_en    (cnt_en),
  .pc_en     (pc_en),
  .init      (init),
  .trap      (trap),
  .bit_idx   (bit_idx),
  .opcode    (opcode),
  .funct3    (funct3),
  .imm       (imm)
);

// File: tb/serial_stage_seq_test.sv
module serial_stage_seq_test;
  localparam logic [31:0] PC0 = 32'hFFFF_FFF8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_ack = 1'b0;
  logic [31:0] fetch_rdata = '0;
  logic        rf_ready = 1'b0;
  logic        fetch_cyc, rf_rreq, cnt_en, pc_en, init, trap, pc_sum;
  logic [31:0] fetch_adr;
  logic [4:0]  bit_idx;
  logic [6:0]  opcode;
  logic [2:0]  funct3;
  logic [11:0] imm;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [31:0] exp_pc = PC0;

  typedef struct {
    logic bitv;
    int   idx;
  } sb_item_t;
  sb_item_t sbq[$];

  always #2 clk = ~clk;

  serial_stage_seq #(.XLEN(32), .PC_RESET(PC0)) uut (
    .clk(clk), .rst_n(rst_n),
    .fetch_cyc(fetch_cyc), .fetch_adr(fetch_adr),
    .fetch_ack(fetch_ack), .fetch_rdata(fetch_rdata),
    .rf_rreq(rf_rreq), .rf_ready(rf_ready),
    .cnt_en(cnt_en), .pc_en(pc_en), .init(init), .trap(trap),
    .bit_idx(bit_idx), .pc_sum(pc_sum),
    .opcode(opcode), .funct3(funct3), .imm(imm)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Monitor: pops the scoreboard during every stage cycle
  always @(negedge clk) begin
    cycles++;
    if (rst_n && cnt_en) begin
      check(pc_en == 1'b1, "R7 pc_en", {31'd0, pc_en}, 32'd1);
      check(!init && !trap, "R8 init/trap", {30'd0, init, trap}, 32'd0);
      check(!fetch_cyc, "R10 no fetch in stage", {31'd0, fetch_cyc}, 32'd0);
      if (sbq.size() == 0) begin
        check(1'b0, "R9 scoreboard empty", {27'd0, bit_idx}, 32'd0);
      end else begin
        sb_item_t it;
        it = sbq.pop_front();
        check(bit_idx == it.idx[4:0], "R6 bit_idx", {27'd0, bit_idx}, it.idx);
        check(pc_sum == it.bitv, "R9 pc_sum", {31'd0, pc_sum}, {31'd0, it.bitv});
      end
    end
  end

  // Watchdog
  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    finish_run();
  end

  // Driver: one instruction with given acknowledge and ready delays
  task automatic run_instr(input logic [31:0] word, input int ack_dly, input int rdy_dly, input logic stray);
    logic [31:0] nxt;
    check(fetch_cyc, "R10 fetch open", {31'd0, fetch_cyc}, 32'd1);
    check(fetch_adr == exp_pc, "R9 fetch address", fetch_adr, exp_pc);
    for (int i = 0; i < ack_dly; i++) begin
      @(negedge clk);
      check(fetch_cyc, "R2 cyc held", {31'd0, fetch_cyc}, 32'd1);
    end
    fetch_ack   = 1'b1;
    fetch_rdata = word;
    nxt = exp_pc + 32'd4;
    for (int k = 0; k < 32; k++) sbq.push_back('{nxt[k], k});
    @(negedge clk);
    fetch_ack   = 1'b0;
    fetch_rdata = ~word;
    check(!fetch_cyc, "R2 cyc dropped", {31'd0, fetch_cyc}, 32'd0);
    check(rf_rreq, "R4 rreq strobe", {31'd0, rf_rreq}, 32'd1);
    check(opcode == word[6:0], "R3 opcode", {25'd0, opcode}, {25'd0, word[6:0]});
    check(funct3 == word[14:12], "R3 funct3", {29'd0, funct3}, {29'd0, word[14:12]});
    check(imm == word[31:20], "R3 imm", {20'd0, imm}, {20'd0, word[31:20]});
    if (stray) fetch_ack = 1'b1;
    for (int i = 0; i < rdy_dly; i++) begin
      @(negedge clk);
      check(!cnt_en, "R5 no early stage", {31'd0, cnt_en}, 32'd0);
      check(!rf_rreq, "R4/R11 single strobe", {31'd0, rf_rreq}, 32'd0);
      check(opcode == word[6:0] && imm == word[31:20], "R11 fields kept", {20'd0, imm}, {20'd0, word[31:20]});
    end
    fetch_ack = 1'b0;
    rf_ready  = 1'b1;
    @(negedge clk);
    rf_ready = 1'b0;
    check(cnt_en, "R5 stage start", {31'd0, cnt_en}, 32'd1);
    check(opcode == word[6:0] && funct3 == word[14:12], "R11 fields after stray", {25'd0, opcode}, {25'd0, word[6:0]});
    repeat (32) @(negedge clk);
    check(!cnt_en && !pc_en, "R6 stage length 32", {30'd0, cnt_en, pc_en}, 32'd0);
    check(fetch_cyc, "R10 refetch", {31'd0, fetch_cyc}, 32'd1);
    check(sbq.size() == 0, "R9 scoreboard drained", sbq.size(), 32'd0);
    exp_pc = nxt;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(fetch_cyc && !cnt_en && !pc_en && !rf_rreq, "R1 reset outputs",
          {28'd0, fetch_cyc, cnt_en, pc_en, rf_rreq}, 32'h8);
    check(bit_idx == 5'd0, "R1 bit_idx", {27'd0, bit_idx}, 32'd0);
    check(fetch_adr == PC0, "R1 fetch_adr", fetch_adr, PC0);
    rst_n = 1'b1;
    @(negedge clk);
    check(fetch_cyc && !cnt_en, "R1 after reset", {30'd0, fetch_cyc, cnt_en}, 32'h2);
    run_instr(32'h00A1_8513, 0, 0, 1'b0);
    run_instr(32'hFFF0_0093, 3, 2, 1'b1);
    run_instr(32'h7FF2_C7B3, 1, 5, 1'b1);
    run_instr(32'h8001_7F37, 2, 0, 1'b0);
    run_instr(32'h1234_5678, 0, 1, 1'b1);
    check(exp_pc == 32'h0000_000C, "R9 wrap reached", exp_pc, 32'h0000_000C);
    finish_run();
  end
endmodule